// File: doc/BRIEF.md
# Selectable-Width 8b/10b Line Encoder

This block turns parallel bytes into DC-balanced 10-bit line code groups for a serial link. Each byte is split into a low 5-bit group, coded to 6 bits, and a high 3-bit group, coded to 4 bits. A running disparity bit decides which of the two complementary forms each sub-block takes, so the line never drifts far from balance. A per-byte control flag selects the special-character set used for commas and framing markers.

A two-bit width selector makes the block code one, two or four bytes per clock. Each byte goes to its own lane. The lanes form a chain: lane 0 starts from the registered disparity, and each later lane starts from the disparity left by the lane below it. The disparity left by the last active lane is stored for the next valid word. The result is registered, so it appears one cycle after the input, and a valid strobe travels with it. The code bit order is fixed: code bit 9 is line bit `a` and is sent first, and code bit 0 is line bit `j`.

Top module: `enc8b10b_multi`

## Requirements
- R1: After reset, `out_valid`, `out_code` and `out_kerr` are all zero, and running disparity is negative, so the first byte after any reset is coded in its negative-disparity form (for example K28.5 gives 0011111010).
- R2: A word accepted with `in_valid` high is presented on the outputs on the next clock with `out_valid` high. A cycle with `in_valid` low gives `out_valid` low on the next clock.
- R3: A data byte b of lane n is coded into `out_code[10n+9:10n]` as {abcdei, fghj}. The group b[4:0] selects the 6-bit sub-block and b[7:5] selects the 4-bit sub-block, following the standard 8b/10b data table.
- R4: The 6-bit sub-block takes its complemented form when the disparity at its start is positive and the base form is unbalanced or equals 111000. After the sub-block, disparity is positive if it has more ones than zeros or equals 000111, and negative if it has more zeros than ones or equals 111000.
- R5: The 4-bit sub-block follows the same rule with 1100 in place of 111000 and 0011 in place of 000111. Its starting disparity is the one left by the 6-bit sub-block.
- R6: Any other balanced sub-block leaves disparity unchanged. Disparity is updated only by words with `in_valid` high; idle cycles leave it unchanged whatever the data inputs carry.
- R7: For b[7:5]=7, the alternate 4-bit code (0111 at negative, 1000 at positive) replaces the primary one in two cases: when the 6-bit disparity is negative and b[4:0] is 17, 18 or 20, and when it is positive and b[4:0] is 11, 13 or 14.
- R8: When a lane's control flag is set, the accepted characters are K28.0 to K28.7, K23.7, K27.7, K29.7 and K30.7. Each is coded in its standard form, and the positive-disparity form is the bitwise complement of the negative one.
- R9: A control flag on any other byte value sets that lane's bit in `out_kerr`, and the byte is coded as a data byte. Words with no control flags give `out_kerr` of zero.
- R10: Modes 00 and 11 code one byte (lane 0). Lanes 1 to 3 of `out_code` and `out_kerr` are zero, and their data and control inputs have no effect.
- R11: Mode 01 codes two bytes, and lane 1 starts from the disparity left by lane 0. Lanes 2 and 3 are zero.
- R12: Mode 10 codes four bytes chained in order from lane 0 to lane 3.
- R13: The disparity stored after a valid word is the one left by its highest active lane, and the next word starts from it, whatever the mode of the next word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is valid this cycle |
| in_mode | input | 2 | Width select: 00/11 one byte, 01 two bytes, 10 four bytes |
| in_data | input | 32 | Bytes, lane n in bits [8n+7:8n] |
| in_ctrl | input | 4 | Per-lane control-character flag |
| out_valid | output | 1 | Output word is valid |
| out_code | output | 40 | Code groups, lane n in bits [10n+9:10n] |
| out_kerr | output | 4 | Per-lane flag: control requested on a byte outside the special set |

## Verification
The lane assertions assume that `in_mode` and `in_ctrl` are stable, known values whenever `in_valid` is high. They also assume that inactive lanes may carry any data, since their weight and disparity are not checked. The stimulus changes inputs only on the falling clock edge. It drives every one of the 256 byte values in single-byte mode, then mixes modes on a pseudo-random stream whose control flags are placed either on legal special characters or, on purpose, on ordinary bytes. Idle cycles carry changing garbage data, so any leak of idle inputs into the stored disparity shows up in the next valid word.

// File: rtl/enc8b10b_pkg.sv
package enc8b10b_pkg;

  localparam int BYTE_W = 8;
  localparam int CODE_W = 10;
  localparam int SUB6_W = 6;
  localparam int SUB4_W = 4;

  typedef enum logic [1:0] {
    WM_ONE     = 2'b00,
    WM_TWO     = 2'b01,
    WM_FOUR    = 2'b10,
    WM_ONE_ALT = 2'b11
  } width_mode_e;

  // number of byte lanes a width selection activates
  function automatic int lanes_for_mode(logic [1:0] m);
    case (width_mode_e'(m))
      WM_TWO:  return 2;
      WM_FOUR: return 4;
      default: return 1;
    endcase
  endfunction

  // 5b -> 6b base form (abcdei), negative-disparity variant
  function automatic logic [5:0] six_base(logic [4:0] x);
    case (x)
      5'd0:  return 6'b100111;  5'd1:  return 6'b011101;
      5'd2:  return 6'b101101;  5'd3:  return 6'b110001;
      5'd4:  return 6'b110101;  5'd5:  return 6'b101001;
      5'd6:  return 6'b011001;  5'd7:  return 6'b111000;
      5'd8:  return 6'b111001;  5'd9:  return 6'b100101;
      5'd10: return 6'b010101;  5'd11: return 6'b110100;
      5'd12: return 6'b001101;  5'd13: return 6'b101100;
      5'd14: return 6'b011100;  5'd15: return 6'b010111;
      5'd16: return 6'b011011;  5'd17: return 6'b100011;
      5'd18: return 6'b010011;  5'd19: return 6'b110010;
      5'd20: return 6'b001011;  5'd21: return 6'b101010;
      5'd22: return 6'b011010;  5'd23: return 6'b111010;
      5'd24: return 6'b110011;  5'd25: return 6'b100110;
      5'd26: return 6'b010110;  5'd27: return 6'b110110;
      5'd28: return 6'b001110;  5'd29: return 6'b101110;
      5'd30: return 6'b011110;  default: return 6'b101011;
    endcase
  endfunction

  // 3b -> 4b base form (fghj), negative-disparity variant
  function automatic logic [3:0] four_base(logic [2:0] y, logic alt);
    case (y)
      3'd0: return 4'b1011;
      3'd1: return 4'b1001;
      3'd2: return 4'b0101;
      3'd3: return 4'b1100;
      3'd4: return 4'b1101;
      3'd5: return 4'b1010;
      3'd6: return 4'b0110;
      default: return alt ? 4'b0111 : 4'b1110;
    endcase
  endfunction

  function automatic logic flip6(logic [5:0] c);
    return ($countones(c) != 3) || (c == 6'b111000);
  endfunction

  function automatic logic flip4(logic [3:0] c);
    return ($countones(c) != 2) || (c == 4'b1100);
  endfunction

  // disparity left behind by a sub-block (1 = positive)
  function automatic logic rd_after6(logic rd, logic [5:0] c);
    int n;
    n = $countones(c);
    if (n > 3) return 1'b1;
    if (n < 3) return 1'b0;
    if (c == 6'b000111) return 1'b1;
    if (c == 6'b111000) return 1'b0;
    return rd;
  endfunction

  function automatic logic rd_after4(logic rd, logic [3:0] c);
    int n;
    n = $countones(c);
    if (n > 2) return 1'b1;
    if (n < 2) return 1'b0;
    if (c == 4'b0011) return 1'b1;
    if (c == 4'b1100) return 1'b0;
    return rd;
  endfunction

  // alternate x.7 code needed to avoid a run of five
  function automatic logic alt7_needed(logic rd_mid, logic [4:0] x);
    if (!rd_mid) return (x == 5'd17) || (x == 5'd18) || (x == 5'd20);
    return (x == 5'd11) || (x == 5'd13) || (x == 5'd14);
  endfunction

  function automatic logic k_allowed(logic [7:0] b);
    if (b[4:0] == 5'd28) return 1'b1;
    return (b[7:5] == 3'd7) &&
           ((b[4:0] == 5'd23) || (b[4:0] == 5'd27) ||
            (b[4:0] == 5'd29) || (b[4:0] == 5'd30));
  endfunction

endpackage

// File: rtl/enc_byte_lane.sv
module enc_byte_lane
  import enc8b10b_pkg::*;
(
  input  logic              rd_in,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              ctrl_in,
  output logic [CODE_W-1:0] code_out,
  output logic              rd_out,
  output logic              kerr_out
);

  logic [4:0]        grp5;
  logic [2:0]        grp3;
  logic              k_ok;
  logic              k28;
  logic [SUB6_W-1:0] base6, sub6;
  logic              rd_mid;
  logic              use_alt;
  logic [SUB4_W-1:0] base4, pos4, sub4;

  assign grp5     = byte_in[4:0];
  assign grp3     = byte_in[7:5];
  assign k_ok     = ctrl_in && k_allowed(byte_in);
  assign k28      = k_ok && (grp5 == 5'd28);
  assign kerr_out = ctrl_in && !k_ok;

  always_comb begin
    base6   = k28 ? 6'b001111 : six_base(grp5);
    sub6    = (rd_in && flip6(base6)) ? ~base6 : base6;
    rd_mid  = rd_after6(rd_in, sub6);
    use_alt = (grp3 == 3'd7) && (k_ok || alt7_needed(rd_mid, grp5));
    base4   = four_base(grp3, use_alt);
    pos4    = flip4(base4) ? ~base4 : base4;
    if (k28)
      sub4 = rd_mid ? pos4 : ~pos4;
    else
      sub4 = rd_mid ? pos4 : base4;
    rd_out   = rd_after4(rd_mid, sub4);
    code_out = {sub6, sub4};
  end

endmodule

// File: rtl/enc_lane_chain.sv
module enc_lane_chain
  import enc8b10b_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                     rd_start,
  input  logic [LANES*BYTE_W-1:0]  data_in,
  input  logic [LANES-1:0]         ctrl_in,
  output logic [LANES*CODE_W-1:0]  code_out,
  output logic [LANES-1:0]         lane_rd_in,
  output logic [LANES-1:0]         lane_rd_out,
  output logic [LANES-1:0]         kerr_out
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_head
      assign lane_rd_in[g] = rd_start;
    end else begin : g_link
      assign lane_rd_in[g] = lane_rd_out[g-1];
    end

    enc_byte_lane u_lane (
      .rd_in    (lane_rd_in[g]),
      .byte_in  (data_in[g*BYTE_W +: BYTE_W]),
      .ctrl_in  (ctrl_in[g]),
      .code_out (code_out[g*CODE_W +: CODE_W]),
      .rd_out   (lane_rd_out[g]),
      .kerr_out (kerr_out[g])
    );
  end

endmodule

// File: rtl/enc8b10b_multi.sv
module enc8b10b_multi
  import enc8b10b_pkg::*;
#(
  parameter int LANES = 4,
  localparam int DATA_W = LANES * BYTE_W,
  localparam int CODE_TOTAL = LANES * CODE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [1:0]            in_mode,
  input  logic [DATA_W-1:0]     in_data,
  input  logic [LANES-1:0]      in_ctrl,
  output logic                  out_valid,
  output logic [CODE_TOTAL-1:0] out_code,
  output logic [LANES-1:0]      out_kerr
);

  logic                  rd_q;
  logic                  rd_next;
  logic [LANES-1:0]      lane_en;
  logic [CODE_TOTAL-1:0] chain_code;
  logic [CODE_TOTAL-1:0] code_gated;
  logic [LANES-1:0]      lane_rd_in;
  logic [LANES-1:0]      lane_rd_out;
  logic [LANES-1:0]      lane_kerr;

  enc_lane_chain #(.LANES(LANES)) u_chain (
    .rd_start    (rd_q),
    .data_in     (in_data),
    .ctrl_in     (in_ctrl),
    .code_out    (chain_code),
    .lane_rd_in  (lane_rd_in),
    .lane_rd_out (lane_rd_out),
    .kerr_out    (lane_kerr)
  );

  always_comb begin
    rd_next = rd_q;
    for (int i = 0; i < LANES; i++) begin
      lane_en[i] = (i < lanes_for_mode(in_mode));
      code_gated[i*CODE_W +: CODE_W] = lane_en[i] ? chain_code[i*CODE_W +: CODE_W] : '0;
      if (lane_en[i]) rd_next = lane_rd_out[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q      <= 1'b0;
      out_valid <= 1'b0;
      out_code  <= '0;
      out_kerr  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        rd_q     <= rd_next;
        out_code <= code_gated;
        out_kerr <= lane_kerr & lane_en;
      end
    end
  end

  // R2
  valid_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  idle_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(rd_q));

  // R9
  kerr_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_ctrl == '0)) |=> (out_kerr == '0));

  if (LANES > 1) begin : g_narrow_chk
    // R10
    narrow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (lanes_for_mode(in_mode) == 1)) |=>
        (out_code[CODE_TOTAL-1:CODE_W] == '0));
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    // R4
    lane_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && lane_en[g]) |->
        (($countones(chain_code[g*CODE_W +: CODE_W]) >= 4) &&
         ($countones(chain_code[g*CODE_W +: CODE_W]) <= 6)));

    // R4
    sub6_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && lane_en[g]) |->
        (($countones(chain_code[g*CODE_W+SUB4_W +: SUB6_W]) >= 2) &&
         ($countones(chain_code[g*CODE_W+SUB4_W +: SUB6_W]) <= 4)));

    // R5
    neg_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && lane_en[g] && !lane_rd_in[g]) |->
        ($countones(chain_code[g*CODE_W +: CODE_W]) >= 5));

    // R5
    pos_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && lane_en[g] && lane_rd_in[g]) |->
        ($countones(chain_code[g*CODE_W +: CODE_W]) <= 5));
  end

endmodule

// File: tb/enc8b10b_multi_test.sv
module enc8b10b_multi_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_mode = 2'b00;
  logic [31:0] in_data = '0;
  logic [3:0]  in_ctrl = '0;
  logic        out_valid;
  logic [39:0] out_code;
  logic [3:0]  out_kerr;

  int checks = 0;
  int fails  = 0;
  logic model_rd = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  bit          q_v[$];
  logic [39:0] q_code[$];
  logic [3:0]  q_kerr[$];
  string       q_req[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  enc8b10b_multi uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_data(in_data), .in_ctrl(in_ctrl), .out_valid(out_valid),
    .out_code(out_code), .out_kerr(out_kerr)
  );

  // reference tables, negative-disparity forms
  function automatic logic [5:0] ref6(int x);
    logic [5:0] t [32] = '{6'b100111, 6'b011101, 6'b101101, 6'b110001,
                           6'b110101, 6'b101001, 6'b011001, 6'b111000,
                           6'b111001, 6'b100101, 6'b010101, 6'b110100,
                           6'b001101, 6'b101100, 6'b011100, 6'b010111,
                           6'b011011, 6'b100011, 6'b010011, 6'b110010,
                           6'b001011, 6'b101010, 6'b011010, 6'b111010,
                           6'b110011, 6'b100110, 6'b010110, 6'b110110,
                           6'b001110, 6'b101110, 6'b011110, 6'b101011};
    return t[x];
  endfunction

  function automatic logic [3:0] ref4(int y);
    logic [3:0] t [8] = '{4'b1011, 4'b1001, 4'b0101, 4'b1100,
                          4'b1101, 4'b1010, 4'b0110, 4'b1110};
    return t[y];
  endfunction

  // full special characters at negative disparity; 0 = not a special
  function automatic logic [9:0] refk(logic [7:0] b);
    logic [3:0] k4 [8] = '{4'b0100, 4'b1001, 4'b0101, 4'b0011,
                           4'b0010, 4'b1010, 4'b0110, 4'b1000};
    if (b[4:0] == 5'd28) return {6'b001111, k4[b[7:5]]};
    case (b)
      8'hF7: return 10'b1110101000;
      8'hFB: return 10'b1101101000;
      8'hFD: return 10'b1011101000;
      8'hFE: return 10'b0111101000;
      default: return 10'b0;
    endcase
  endfunction

  function automatic void ref_byte(input logic rd, input logic [7:0] b, input bit k,
                                   output logic [9:0] c, output logic rd_o,
                                   output bit kerr);
    logic [9:0] kc;
    logic [5:0] s6;
    logic [3:0] s4;
    logic mid;
    int x, y, n6;
    kc = refk(b);
    kerr = k && (kc == 10'b0);
    if (k && !kerr) begin
      c = rd ? ~kc : kc;
    end else begin
      x = int'(b[4:0]);
      y = int'(b[7:5]);
      s6 = ref6(x);
      if (rd && (($countones(s6) != 3) || s6 == 6'b111000)) s6 = ~s6;
      n6 = $countones(s6);
      if (n6 > 3 || s6 == 6'b000111) mid = 1'b1;
      else if (n6 < 3 || s6 == 6'b111000) mid = 1'b0;
      else mid = rd;
      s4 = ref4(y);
      // R7 alternate x.7
      if (y == 7 && ((!mid && (x == 17 || x == 18 || x == 20)) ||
                     (mid && (x == 11 || x == 13 || x == 14))))
        s4 = 4'b0111;
      if (mid && (($countones(s4) != 2) || s4 == 4'b1100)) s4 = ~s4;
      c = {s6, s4};
    end
    rd_o = ($countones(c) == 5) ? rd : ~rd;
  endfunction

  task automatic send(input bit v, input logic [1:0] mode, input logic [31:0] d,
                      input logic [3:0] k, input string req);
    logic [39:0] ec;
    logic [3:0]  ek;
    int nl;
    @(negedge clk);
    in_valid = v; in_mode = mode; in_data = d; in_ctrl = k;
    ec = '0; ek = '0;
    if (v) begin
      nl = (mode == 2'b01) ? 2 : (mode == 2'b10) ? 4 : 1;
      for (int i = 0; i < nl; i++) begin
        logic [9:0] c; logic r; bit e;
        ref_byte(model_rd, d[i*8 +: 8], k[i], c, r, e);
        ec[i*10 +: 10] = c; ek[i] = e; model_rd = r;
      end
    end
    q_v.push_back(v); q_code.push_back(ec); q_kerr.push_back(ek); q_req.push_back(req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      send(1'b0, seed[1:0], seed, seed[7:4], "R6");
    end
  endtask

  task automatic check_reset_state(input string req);
    checks++;
    if (out_valid !== 1'b0 || out_code !== '0 || out_kerr !== '0) begin
      fails++;
      $display("FAIL %s reset state: valid=%b code=%h kerr=%h expected 0/0/0",
               req, out_valid, out_code, out_kerr);
    end
  endtask

  task automatic do_reset();
    idle(2);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    model_rd = 1'b0;
    repeat (2) @(negedge clk);
    check_reset_state("R1");
    rst_n = 1'b1;
  endtask

  function automatic logic [7:0] pick_k(int i);
    logic [7:0] t [12] = '{8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC,
                           8'hDC, 8'hFC, 8'hF7, 8'hFB, 8'hFD, 8'hFE};
    return t[i % 12];
  endfunction

  // monitor / scoreboard
  always @(posedge clk) begin
    #1;
    if (q_v.size() != 0) begin
      bit ev; logic [39:0] ecode; logic [3:0] ekerr; string rq;
      ev = q_v.pop_front(); ecode = q_code.pop_front();
      ekerr = q_kerr.pop_front(); rq = q_req.pop_front();
      checks++;
      if (out_valid !== ev) begin
        fails++;
        $display("FAIL %s R2 out_valid: got %b expected %b", rq, out_valid, ev);
      end else if (ev && (out_code !== ecode || out_kerr !== ekerr)) begin
        fails++;
        $display("FAIL %s code/kerr: got %h/%h expected %h/%h",
                 rq, out_code, out_kerr, ecode, ekerr);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state("R1");
    rst_n = 1'b1;

    // R1 first byte after reset at negative disparity: K28.5
    send(1'b1, 2'b00, 32'h0000_00BC, 4'h1, "R1");
    // R3 R4 R5 every byte value in single-byte mode
    for (int i = 0; i < 256; i++) send(1'b1, 2'b00, i, 4'h0, "R3");
    // R7 alternate codes at both disparities
    for (int i = 0; i < 2; i++) begin
      send(1'b1, 2'b00, 32'hF1, 4'h0, "R7");
      send(1'b1, 2'b00, 32'hF2, 4'h0, "R7");
      send(1'b1, 2'b00, 32'hF4, 4'h0, "R7");
      send(1'b1, 2'b00, 32'hEB, 4'h0, "R7");
      send(1'b1, 2'b00, 32'hED, 4'h0, "R7");
      send(1'b1, 2'b00, 32'hEE, 4'h0, "R7");
      send(1'b1, 2'b00, 32'h1C, 4'h1, "R7");
    end
    // R4 R5 biased balanced blocks: D7.3 and neighbours
    for (int i = 0; i < 3; i++) begin
      send(1'b1, 2'b00, 32'h67, 4'h0, "R4");
      send(1'b1, 2'b00, 32'h63, 4'h0, "R5");
      send(1'b1, 2'b00, 32'h3C, 4'h1, "R5");
    end
    // R8 all special characters, twice for both disparities
    for (int i = 0; i < 24; i++) send(1'b1, 2'b00, pick_k(i), 4'h1, "R8");
    // R9 control on ordinary bytes
    send(1'b1, 2'b00, 32'h00, 4'h1, "R9");
    send(1'b1, 2'b00, 32'hBD, 4'h1, "R9");
    send(1'b1, 2'b10, 32'hBC17_5C00, 4'hF, "R9");
    // R6 idle garbage between words
    send(1'b1, 2'b00, 32'hBC, 4'h1, "R6");
    idle(4);
    send(1'b1, 2'b00, 32'h07, 4'h0, "R6");
    // R10 inactive lanes ignored
    send(1'b1, 2'b00, 32'hFFFF_FF55, 4'hE, "R10");
    send(1'b1, 2'b11, 32'h1234_56BC, 4'hF, "R10");
    // R11 two lanes
    send(1'b1, 2'b01, 32'hAAAA_BC4A, 4'hE, "R11");
    send(1'b1, 2'b01, 32'h0000_0707, 4'h0, "R11");
    // R12 four lanes
    send(1'b1, 2'b10, 32'hBCBC_BCBC, 4'hF, "R12");
    send(1'b1, 2'b10, 32'h0102_0304, 4'h0, "R12");
    // R13 mixed modes, pseudo-random
    for (int i = 0; i < 300; i++) begin
      logic [31:0] d; logic [3:0] k; logic [1:0] m;
      seed = seed * 32'd1664525 + 32'd1013904223;
      d = seed;
      m = seed[31:30];
      seed = seed * 32'd1664525 + 32'd1013904223;
      k = (seed[3:0] & seed[7:4]);
      for (int j = 0; j < 4; j++)
        if (k[j] && seed[8+j]) d[j*8 +: 8] = pick_k(int'(seed[15:12]) + j);
      if (seed[20:18] == 3'd0) idle(1);
      send(1'b1, m, d, k, "R13");
    end
    // R1 reset mid-run with positive disparity pending
    send(1'b1, 2'b00, 32'hBC, 4'h1, "R1");
    do_reset();
    send(1'b1, 2'b00, 32'hBC, 4'h1, "R1");
    send(1'b1, 2'b10, 32'h5555_5555, 4'h0, "R12");
    idle(3);
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule